// File: doc/BRIEF.md
# Quad Double-Buffered Channel Register Bank

This block sits behind a serial command receiver and holds the codes for four converter channels. Every channel keeps two 8-bit registers. A staging register can be written on its own. An output register drives the converter. A command word arrives in parallel together with a one-cycle strobe. The strobe marks the moment the chip-select line goes inactive.

A command can do one of three things to the registers. It can stage data for one channel and leave every output alone. It can stage data for one channel and then commit all four staging registers to the outputs in the same edge. It can commit all four channels without writing any data. Two further command codes choose the output-edge mode of the serial front end.

An active-low commit pin gives a hardware path to the same all-channel commit. The pin is synchronized and its falling edge is detected. Because of this, several channels can be staged in advance and then switched together.

Top module: `qdb_bank`

## Requirements
- R1: After reset every output register and every staging register holds 0, and edge_mode is 0.
- R2: The command word is {addr[11:10], ctl[9:8], data[7:0]}; bit 11 is the first bit received. The addr field selects the channel, and channel n appears on dac_out[8n+7:8n].
- R3: With ctl=01, data is written to the staging register of the addressed channel. No output register changes.
- R4: With ctl=11, data is written to the addressed staging register, and all four output registers take their staging values, including the new data. dac_out shows this one clock after the strobe.
- R5: With ctl=00 and addr=01, every staging register is copied to its output register. The data field is ignored.
- R6: With ctl=00, addr=10 sets edge_mode to 0 and addr=11 sets it to 1. ctl=00 with addr=00, and ctl=10 with any addr, do nothing. None of these codes changes any output register.
- R7: A falling edge on ldac_n, after a SYNC_STAGES-flop synchronizer, commits all staging registers to the outputs. With the default depth, dac_out changes on the third rising edge after ldac_n goes low. Holding ldac_n low does not cause another commit.
- R8: When a strobe and a detected ldac_n falling edge land in the same cycle, the command takes effect first. The commit then uses the staging values as that command updated them.
- R9: While cmd_valid is low, cmd_word has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: command word complete |
| cmd_word | input | 12 | Command {addr, ctl, data} |
| ldac_n | input | 1 | Asynchronous active-low commit request |
| dac_out | output | 32 | Four output registers, channel 0 in the low byte |
| edge_mode | output | 1 | Selected serial output edge (0 falling, 1 rising) |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit data and a two-flop synchronizer. With these values the 12-bit word can be drawn at random, so every address, every control code and many data patterns are reached in a few hundred commands. The commit pin has a fixed three-edge latency. Because that latency is fixed, the bench can place a command strobe in exactly the cycle where the detected edge fires and check the command-first ordering.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

    // Control field of a command word
    typedef enum logic [1:0] {
        CTL_SPECIAL = 2'b00,
        CTL_STAGE   = 2'b01,
        CTL_RSVD    = 2'b10,
        CTL_STAGE_COMMIT = 2'b11
    } ctl_e;

    // Sub-codes carried in the address field when ctl is CTL_SPECIAL
    localparam logic [1:0] SUB_NOP    = 2'b00;
    localparam logic [1:0] SUB_COMMIT = 2'b01;
    localparam logic [1:0] SUB_EDGE_F = 2'b10;
    localparam logic [1:0] SUB_EDGE_R = 2'b11;

    function automatic ctl_e ctl_of(input logic [1:0] bits);
        return ctl_e'(bits);
    endfunction

endpackage

// File: rtl/qdb_cmd_decode.sv
module qdb_cmd_decode
    import qdb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    localparam int ADDR_W = (NUM_CH > 4) ? $clog2(NUM_CH) : 2,
    localparam int CMD_W  = ADDR_W + 2 + DATA_W
) (
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              xfer_cmd,
    output logic              mode_set,
    output logic              mode_val
);
    logic [ADDR_W-1:0] addr;
    ctl_e              ctl;

    always_comb begin
        addr     = cmd_word[CMD_W-1 -: ADDR_W];
        ctl      = ctl_of(cmd_word[DATA_W+1:DATA_W]);
        wr_data  = cmd_word[DATA_W-1:0];
        wr_sel   = '0;
        xfer_cmd = 1'b0;
        mode_set = 1'b0;
        mode_val = 1'b0;
        if (cmd_valid) begin
            unique case (ctl)
                CTL_STAGE, CTL_STAGE_COMMIT: begin
                    for (int i = 0; i < NUM_CH; i++)
                        wr_sel[i] = (addr == ADDR_W'(i));
                    xfer_cmd = (ctl == CTL_STAGE_COMMIT);
                end
                CTL_SPECIAL: begin
                    if (addr == ADDR_W'(SUB_COMMIT)) xfer_cmd = 1'b1;
                    if (addr == ADDR_W'(SUB_EDGE_F) || addr == ADDR_W'(SUB_EDGE_R)) begin
                        mode_set = 1'b1;
                        mode_val = (addr == ADDR_W'(SUB_EDGE_R));
                    end
                end
                default: ; // reserved code: no action
            endcase
        end
    end
endmodule

// File: rtl/qdb_ldac_sync.sv
module qdb_ldac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ldac_n,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], ldac_n};
            prev  <= chain[STAGES-1];
        end
    end

    assign fall = prev & ~chain[STAGES-1];

    // R7: a held-low pin yields a single commit pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/qdb_channel.sv
module qdb_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer,
    output logic [DATA_W-1:0] stage_q,
    output logic [DATA_W-1:0] dac_q
);
    logic [DATA_W-1:0] stage_next;

    always_comb stage_next = wr_en ? wr_data : stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            dac_q   <= '0;
        end else begin
            stage_q <= stage_next;
            if (xfer) dac_q <= stage_next;
        end
    end

    // R3: the output register moves only on a commit
    a_r3_dac_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(dac_q));
    // R4: after a commit the output equals the staging register
    a_r4_dac_follows: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (dac_q == stage_q));
    // R9: staging register holds without a write
    a_r9_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(stage_q));
endmodule

// File: rtl/qdb_bank.sv
module qdb_bank
    import qdb_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = (NUM_CH > 4) ? $clog2(NUM_CH) : 2,
    localparam int CMD_W  = ADDR_W + 2 + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [CMD_W-1:0]         cmd_word,
    input  logic                     ldac_n,
    output logic [NUM_CH*DATA_W-1:0] dac_out,
    output logic                     edge_mode
);
    logic [NUM_CH-1:0] wr_sel;
    logic [DATA_W-1:0] wr_data;
    logic              xfer_cmd;
    logic              mode_set;
    logic              mode_val;
    logic              ldac_fall;
    logic              xfer_all;

    qdb_cmd_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .xfer_cmd  (xfer_cmd),
        .mode_set  (mode_set),
        .mode_val  (mode_val)
    );

    qdb_ldac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ldac_n (ldac_n),
        .fall   (ldac_fall)
    );

    // Command write and pin commit share one edge; the write feeds the commit.
    assign xfer_all = xfer_cmd | ldac_fall;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [DATA_W-1:0] stage_q;
        qdb_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_sel[g]),
            .wr_data (wr_data),
            .xfer    (xfer_all),
            .stage_q (stage_q),
            .dac_q   (dac_out[g*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           edge_mode <= 1'b0;
        else if (mode_set) edge_mode <= mode_val;
    end

    // R1: reset clears outputs and mode
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (dac_out == '0 && edge_mode == 1'b0));
    // R2: at most one staging register is addressed
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));
    // R6: mode and no-op codes leave the outputs alone
    a_r6_special_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ctl_of(cmd_word[DATA_W+1:DATA_W]) == CTL_SPECIAL
         && cmd_word[CMD_W-1 -: ADDR_W] != ADDR_W'(SUB_COMMIT) && !ldac_fall)
        |=> $stable(dac_out));
    // R9: no strobe, no mode change
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(edge_mode));
endmodule

// File: tb/tb_qdb_bank.sv
`timescale 1ns/1ps
module tb_qdb_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [11:0] cmd_word;
    logic        ldac_n;
    logic [31:0] dac_out;
    logic        edge_mode;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_in  [4];
    logic [7:0] exp_dac [4];
    logic       exp_mode;

    always #2.5 clk = ~clk;

    qdb_bank dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ldac_n(ldac_n), .dac_out(dac_out), .edge_mode(edge_mode)
    );

    function automatic logic [31:0] exp_bus();
        return {exp_dac[3], exp_dac[2], exp_dac[1], exp_dac[0]};
    endfunction

    function automatic logic [11:0] mk(input logic [1:0] a, input logic [1:0] c, input logic [7:0] d);
        return {a, c, d};
    endfunction

    task automatic commit_model();
        for (int i = 0; i < 4; i++) exp_dac[i] = exp_in[i];
    endtask

    task automatic apply_model(input logic [11:0] w);
        logic [1:0] a;
        logic [1:0] c;
        a = w[11:10];
        c = w[9:8];
        case (c)
            2'b01: exp_in[a] = w[7:0];
            2'b11: begin exp_in[a] = w[7:0]; commit_model(); end
            2'b00: begin
                if (a == 2'b01) commit_model();
                else if (a == 2'b10) exp_mode = 1'b0;
                else if (a == 2'b11) exp_mode = 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic check(input string req);
        checks++;
        if (dac_out !== exp_bus() || edge_mode !== exp_mode) begin
            errors++;
            $display("FAIL %s: dac_out=%h edge_mode=%b expected dac_out=%h edge_mode=%b",
                     req, dac_out, edge_mode, exp_bus(), exp_mode);
        end
    endtask

    task automatic send(input logic [11:0] w, input string req);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = $urandom;
        apply_model(w);
        check(req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; cmd_valid = 1'b0; cmd_word = '0; ldac_n = 1'b1;
        for (int i = 0; i < 4; i++) begin exp_in[i] = '0; exp_dac[i] = '0; end
        exp_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state");

        // R3: stage three channels, outputs stay at zero
        send(mk(2'd0, 2'b01, 8'h40), "R3 stage ch0");
        send(mk(2'd1, 2'b01, 8'h80), "R3 stage ch1");
        send(mk(2'd2, 2'b01, 8'hC0), "R3 stage ch2");
        // R4/R2: stage-and-commit on ch3 commits all four
        send(mk(2'd3, 2'b11, 8'hFF), "R4 stage+commit ch3");

        // R5: software commit ignores data
        send(mk(2'd1, 2'b01, 8'h11), "R3 stage ch1 only");
        send(mk(2'd1, 2'b00, 8'hAA), "R5 software commit, data ignored");

        // R6: mode codes and no-ops
        send(mk(2'd3, 2'b00, 8'h5A), "R6 edge mode rising");
        send(mk(2'd0, 2'b00, 8'h77), "R6 nop code");
        send(mk(2'd2, 2'b10, 8'h33), "R6 reserved ctl=10");
        send(mk(2'd2, 2'b00, 8'h00), "R6 edge mode falling");

        // R9: garbage words without strobe
        for (int k = 0; k < 5; k++) begin
            cmd_word = $urandom;
            @(negedge clk);
        end
        check("R9 no strobe, no change");

        // R7: pin commit after three edges, once only
        send(mk(2'd2, 2'b01, 8'h9C), "R3 stage ch2");
        ldac_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R7 no commit before third edge");
        @(negedge clk);
        commit_model();
        check("R7 pin commit");
        send(mk(2'd0, 2'b01, 8'h21), "R3 stage ch0 while pin low");
        repeat (4) @(negedge clk);
        check("R7 held low, no second commit");
        ldac_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 rising pin, no commit");

        // R8: strobe in the same cycle as the detected pin edge
        ldac_n = 1'b0;
        @(negedge clk); @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = mk(2'd3, 2'b01, 8'hE7);
        @(negedge clk);
        cmd_valid = 1'b0;
        apply_model(mk(2'd3, 2'b01, 8'hE7));
        commit_model();
        check("R8 command first, then commit");
        ldac_n = 1'b1;
        repeat (3) @(negedge clk);

        // Random commands with occasional pin commits
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 16) == 0) begin
                ldac_n = 1'b0;
                repeat (3) @(negedge clk);
                commit_model();
                check("R7 random pin commit");
                ldac_n = 1'b1;
                repeat (3) @(negedge clk);
            end else begin
                send(12'($urandom), "R2 random command");
            end
        end

        finish_run();
    end
endmodule